// File: doc/BRIEF.md
# Single-Channel Bus-Mastering Block Transfer Controller

This block moves a run of 32-bit words between one peripheral and memory so that the processor does not touch each word. Software loads a starting byte address and a number of words, then writes a control word that carries a start bit and the direction. From then on the peripheral asks for each word with a request line. Once the bus owner also gives the bus, the controller runs one bus cycle. In that cycle it acknowledges the peripheral, drives the memory address and raises one memory strobe and one I/O strobe together, so one bus cycle moves the word.

After every word the address steps up by four bytes and the remaining count steps down by one. The controller then gives the bus back for at least one clock, so processor cycles and transfer cycles take turns. When the count reaches zero the controller goes idle and raises a sticky interrupt flag. The flag stays set until software clears it.

The data itself never passes through the controller. The peripheral and the memory exchange it on the shared data lines while the controller supplies the address and the strobes.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset the controller is idle: the status, address and count registers read 0, and `irq`, `dev_ack`, `bus_req` and all four strobes are low.
- R2: Register select values: 0 is the start address, 1 is the word count, 2 is control on write (bit 0 start, bit 1 direction, bit 2 interrupt clear) and status on read (bit 0 busy, bit 1 interrupt flag, bit 2 direction), and 3 reads as 0. A start written while idle with a nonzero count sets busy at the next clock edge.
- R3: A transfer cycle begins only at the clock edge after one at which the controller was waiting with `dev_req` and `bus_grant` both high. With either one low, no acknowledge and no strobe appears.
- R4: A transfer cycle lasts exactly one clock. During it `dev_ack` is high and `mem_addr` equals the current address register. Outside a cycle `mem_addr` is 0.
- R5: Direction 0 (peripheral to memory) raises `mem_wr` and `io_rd` during the cycle. Direction 1 (memory to peripheral) raises `mem_rd` and `io_wr`. The other two strobes stay low, and all four are low outside a cycle.
- R6: At the edge that ends each word, the address register increases by 4, wrapping modulo 2^ADDR_W, and the count register decreases by 1.
- R7: After each word `bus_req` and `dev_ack` are both low for at least one clock, even while the peripheral holds its request.
- R8: At the edge that ends the last word, busy clears and the interrupt flag (`irq`) sets.
- R9: The interrupt flag stays set until a control write with bit 2 set. A control write without bit 2 leaves it set.
- R10: While busy, writes to start, address, count or direction have no effect.
- R11: A start written while idle with a count of 0 runs no bus cycle, leaves busy clear and sets the interrupt flag at the next edge.
- R12: `bus_req` is high while waiting with `dev_req` high, whatever `bus_grant` is, and it stays high through the transfer cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data for `cfg_sel` (combinational) |
| dev_req | input | 1 | Peripheral asks for one word |
| dev_ack | output | 1 | Acknowledge to the peripheral, high for the transfer cycle |
| bus_req | output | 1 | Request for the shared bus |
| bus_grant | input | 1 | Bus given to the controller |
| mem_addr | output | ADDR_W | Memory byte address during a transfer cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| irq | output | 1 | Sticky completion interrupt |

## Verification
Inputs are driven on the falling edge. A request seen together with the grant at a rising edge produces the acknowledge, the address and the strobes at the next falling edge, and the bench samples them there. Address and count updates, the busy drop and the interrupt flag all come from the rising edge that closes the cycle, so the bench reads them on the falling edge after the acknowledge. A start or a clear takes effect at the rising edge inside the bench's write task, so it is visible as soon as the task returns. Register reads are combinational and are sampled one time step after the select changes.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2,
    ST_GAP  = 2'd3
  } dma_state_e;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  localparam int CTL_START = 0;
  localparam int CTL_DIR   = 1;
  localparam int CTL_CLR   = 2;

  localparam int STS_BUSY  = 0;
  localparam int STS_IRQ   = 1;
  localparam int STS_DIR   = 2;

  localparam logic DIR_TO_MEM = 1'b0;
  localparam logic DIR_TO_DEV = 1'b1;
endpackage

// File: rtl/dma_cfg_port.sv
module dma_cfg_port
  import dma_xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              idle,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [CNT_W-1:0]  cur_count,
  input  logic              cur_dir,
  input  logic              irq_flag,
  output logic              load_addr,
  output logic              load_count,
  output logic              start_req,
  output logic              irq_clr,
  output logic              dir_val,
  output logic [DATA_W-1:0] cfg_rdata
);
  logic ctrl_wr;

  assign ctrl_wr    = cfg_we && (cfg_sel == SEL_CTRL);
  assign load_addr  = cfg_we && (cfg_sel == SEL_ADDR) && idle;
  assign load_count = cfg_we && (cfg_sel == SEL_COUNT) && idle;
  assign start_req  = ctrl_wr && cfg_wdata[CTL_START] && idle;
  assign irq_clr    = ctrl_wr && cfg_wdata[CTL_CLR];
  assign dir_val    = cfg_wdata[CTL_DIR];

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_sel)
      SEL_ADDR:  cfg_rdata = DATA_W'(cur_addr);
      SEL_COUNT: cfg_rdata = DATA_W'(cur_count);
      SEL_CTRL: begin
        cfg_rdata[STS_BUSY] = !idle;
        cfg_rdata[STS_IRQ]  = irq_flag;
        cfg_rdata[STS_DIR]  = cur_dir;
      end
      default:   cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
  import dma_xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_addr,
  input  logic              load_count,
  input  logic              start_req,
  input  logic              irq_clr,
  input  logic              dir_val,
  input  logic [DATA_W-1:0] wdata,
  input  logic              word_done,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_count,
  output logic              cur_dir,
  output logic              count_zero,
  output logic              last_word,
  output logic              zero_done,
  output logic              irq_flag
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + STEP;
  endfunction

  function automatic logic [CNT_W-1:0] count_dec(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  assign count_zero = (cur_count == '0);
  assign last_word  = (cur_count == CNT_W'(1));
  assign zero_done  = start_req && count_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_count <= '0;
      cur_dir   <= DIR_TO_MEM;
    end else begin
      if (load_addr)
        cur_addr <= ADDR_W'(wdata);
      else if (word_done)
        cur_addr <= addr_step(cur_addr);

      if (load_count)
        cur_count <= CNT_W'(wdata);
      else if (word_done)
        cur_count <= count_dec(cur_count);

      if (start_req)
        cur_dir <= dir_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      irq_flag <= 1'b0;
    else if ((word_done && last_word) || zero_done)
      irq_flag <= 1'b1;
    else if (irq_clr)
      irq_flag <= 1'b0;
  end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_xfer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_go,
  input  logic dev_req,
  input  logic bus_grant,
  input  logic last_word,
  output logic idle,
  output logic in_xfer,
  output logic word_done,
  output logic bus_req
);
  dma_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (start_go) state_nx = ST_WAIT;
      ST_WAIT: if (dev_req && bus_grant) state_nx = ST_XFER;
      ST_XFER: state_nx = last_word ? ST_IDLE : ST_GAP;
      ST_GAP:  state_nx = ST_WAIT;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign idle      = (state == ST_IDLE);
  assign in_xfer   = (state == ST_XFER);
  assign word_done = in_xfer;
  assign bus_req   = ((state == ST_WAIT) && dev_req) || in_xfer;
endmodule

// File: rtl/dma_strobe_gen.sv
module dma_strobe_gen
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              in_xfer,
  input  logic              cur_dir,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr
);
  logic to_mem, to_dev;

  assign to_mem   = in_xfer && (cur_dir == DIR_TO_MEM);
  assign to_dev   = in_xfer && (cur_dir == DIR_TO_DEV);
  assign mem_wr   = to_mem;
  assign io_rd    = to_mem;
  assign mem_rd   = to_dev;
  assign io_wr    = to_dev;
  assign mem_addr = in_xfer ? cur_addr : '0;
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              dev_req,
  output logic              dev_ack,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  output logic              irq
);
  logic              idle, in_xfer, word_done;
  logic              load_addr, load_count, start_req, irq_clr, dir_val;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_count;
  logic              cur_dir, count_zero, last_word, zero_done, irq_flag;
  logic              start_go, busy;

  assign start_go = start_req && !count_zero;
  assign busy     = !idle;
  assign dev_ack  = in_xfer;
  assign irq      = irq_flag;

  dma_cfg_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .idle(idle), .cur_addr(cur_addr), .cur_count(cur_count),
    .cur_dir(cur_dir), .irq_flag(irq_flag),
    .load_addr(load_addr), .load_count(load_count), .start_req(start_req),
    .irq_clr(irq_clr), .dir_val(dir_val), .cfg_rdata(cfg_rdata)
  );

  dma_xfer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
                  .WORD_BYTES(WORD_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .load_addr(load_addr), .load_count(load_count), .start_req(start_req),
    .irq_clr(irq_clr), .dir_val(dir_val), .wdata(cfg_wdata),
    .word_done(word_done),
    .cur_addr(cur_addr), .cur_count(cur_count), .cur_dir(cur_dir),
    .count_zero(count_zero), .last_word(last_word), .zero_done(zero_done),
    .irq_flag(irq_flag)
  );

  dma_xfer_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_go(start_go),
    .dev_req(dev_req), .bus_grant(bus_grant), .last_word(last_word),
    .idle(idle), .in_xfer(in_xfer), .word_done(word_done), .bus_req(bus_req)
  );

  dma_strobe_gen #(.ADDR_W(ADDR_W)) u_strb (
    .in_xfer(in_xfer), .cur_dir(cur_dir), .cur_addr(cur_addr),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr)
  );
endmodule

// File: rtl/dma_xfer_ctrl_chk.sv
module dma_xfer_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dev_req,
  input logic              bus_grant,
  input logic              dev_ack,
  input logic              bus_req,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              io_rd,
  input logic              io_wr,
  input logic              irq,
  input logic              busy,
  input logic              irq_clr,
  input logic              word_done,
  input logic              last_word,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [CNT_W-1:0]  cur_count
);
  AST_CYCLE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_ack) |-> $past(dev_req && bus_grant));  // R3
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |=> !dev_ack);  // R4
  AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> ((mem_wr ^ mem_rd) && (mem_wr == io_rd) && (mem_rd == io_wr)));  // R5
  AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_ack |-> !(mem_wr || mem_rd || io_wr || io_rd));  // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (cur_addr == $past(cur_addr) + ADDR_W'(4)));  // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (cur_count == $past(cur_count) - CNT_W'(1)));  // R6
  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |=> (!bus_req && !dev_ack));  // R7
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && last_word) |=> (irq && !busy));  // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);  // R9
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> bus_req);  // R12
endmodule

bind dma_xfer_ctrl dma_xfer_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .bus_grant(bus_grant),
  .dev_ack(dev_ack), .bus_req(bus_req), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .io_rd(io_rd), .io_wr(io_wr), .irq(irq), .busy(busy), .irq_clr(irq_clr),
  .word_done(word_done), .last_word(last_word),
  .cur_addr(cur_addr), .cur_count(cur_count)
);

// File: tb/dma_xfer_ctrl_bench.sv
module dma_xfer_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        dev_req = 1'b0;
  logic        dev_ack, bus_req;
  logic        bus_grant = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rd, mem_wr, io_rd, io_wr, irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  // transfer table: {direction, start address, word count}
  localparam logic [48:0] VEC [0:2] = '{
    {1'b0, 32'h0000_1000, 16'd3},
    {1'b1, 32'h8000_0FF4, 16'd5},
    {1'b0, 32'hFFFF_FFF8, 16'd2}
  };

  always #10 clk = ~clk;

  dma_xfer_ctrl u_dma_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_req(dev_req),
    .dev_ack(dev_ack), .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] val);
    cfg_sel = sel;
    #1;
    val = cfg_rdata;
  endtask

  function automatic logic [3:0] strobes();
    return {mem_rd, mem_wr, io_rd, io_wr};
  endfunction

  // expected strobes {mem_rd, mem_wr, io_rd, io_wr} for a direction
  function automatic logic [3:0] exp_strb(input logic dir);
    return dir ? 4'b1001 : 4'b0110;
  endfunction

  task automatic wait_ack(input string tag);
    int k;
    for (k = 0; k < 8 && !dev_ack; k++) @(negedge clk);
    check(tag, {31'd0, dev_ack}, 32'd1);
  endtask

  task automatic run_words(input logic dir, input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      wait_ack("R3 ack after req and grant");
      check("R4 mem_addr during cycle", mem_addr, base + 32'(4 * i));
      check("R5 strobes by direction", {28'd0, strobes()}, {28'd0, exp_strb(dir)});
      @(negedge clk);
      check("R7 bus released after word", {30'd0, bus_req, dev_ack}, 32'd0);
      check("R5 strobes low after cycle", {28'd0, strobes()}, 32'd0);
      check("R4 mem_addr idle value", mem_addr, 32'd0);
      rd(2'd0, rv);
      check("R6 address stepped", rv, base + 32'(4 * (i + 1)));
      rd(2'd1, rv);
      check("R6 count stepped", rv, 32'(n - i - 1));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd2, rv); check("R1 status after reset", rv, 32'd0);
    rd(2'd0, rv); check("R1 address after reset", rv, 32'd0);
    rd(2'd1, rv); check("R1 count after reset", rv, 32'd0);
    rd(2'd3, rv); check("R2 select 3 reads zero", rv, 32'd0);
    check("R1 outputs after reset",
          {26'd0, irq, dev_ack, bus_req, strobes() != 4'd0, 2'b00}, 32'd0);

    // table-driven transfers
    for (int v = 0; v < 3; v++) begin
      logic        dir;
      logic [31:0] base;
      int          n;
      dir = VEC[v][48]; base = VEC[v][47:16]; n = int'(VEC[v][15:0]);
      cfg_wr(2'd0, base);
      cfg_wr(2'd1, 32'(n));
      cfg_wr(2'd2, {29'd0, 1'b0, dir, 1'b1});
      rd(2'd2, rv);
      check("R2 busy after start", rv, {29'd0, dir, 1'b0, 1'b1});
      dev_req = 1'b1; bus_grant = 1'b1;
      run_words(dir, base, n);
      dev_req = 1'b0; bus_grant = 1'b0;
      rd(2'd2, rv);
      check("R8 busy clear irq set at end", rv, {29'd0, dir, 1'b1, 1'b0});
      check("R8 irq pin", {31'd0, irq}, 32'd1);
      cfg_wr(2'd2, 32'h4);
      check("R9 irq cleared", {31'd0, irq}, 32'd0);
    end

    // grant withheld, request withheld, writes while busy
    cfg_wr(2'd0, 32'h0000_4000);
    cfg_wr(2'd1, 32'd2);
    cfg_wr(2'd2, 32'h1);
    dev_req = 1'b1; bus_grant = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 no cycle without grant", {27'd0, dev_ack, strobes()}, 32'd0);
    check("R12 bus_req while waiting", {31'd0, bus_req}, 32'd1);
    dev_req = 1'b0; bus_grant = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 no cycle without request", {31'd0, dev_ack}, 32'd0);
    check("R12 no bus_req without request", {31'd0, bus_req}, 32'd0);
    bus_grant = 1'b0;
    cfg_wr(2'd2, 32'h3);
    cfg_wr(2'd0, 32'h5555_5554);
    cfg_wr(2'd1, 32'd9);
    rd(2'd2, rv); check("R10 direction kept while busy", rv, 32'h1);
    rd(2'd0, rv); check("R10 address kept while busy", rv, 32'h0000_4000);
    rd(2'd1, rv); check("R10 count kept while busy", rv, 32'd2);
    dev_req = 1'b1; bus_grant = 1'b1;
    run_words(1'b0, 32'h0000_4000, 2);
    dev_req = 1'b0; bus_grant = 1'b0;

    // R9 sticky flag
    repeat (5) @(negedge clk);
    check("R9 irq held", {31'd0, irq}, 32'd1);
    cfg_wr(2'd2, 32'h0);
    check("R9 irq held after write without clear", {31'd0, irq}, 32'd1);
    cfg_wr(2'd2, 32'h4);
    check("R9 irq cleared by bit 2", {31'd0, irq}, 32'd0);

    // R11 zero count start
    cfg_wr(2'd1, 32'd0);
    dev_req = 1'b1; bus_grant = 1'b1;
    cfg_wr(2'd2, 32'h1);
    rd(2'd2, rv); check("R11 zero count: irq set, not busy", rv, 32'h2);
    begin
      int acks;
      acks = 0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (dev_ack) acks++;
      end
      check("R11 no bus cycle on zero count", 32'(acks), 32'd0);
    end
    dev_req = 1'b0; bus_grant = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule